// File: doc/BRIEF.md
# Converter Conversion-Start Arbiter

This block decides the moment a data-converter sequencer begins a conversion. A start can come from a software request or, when automatic triggering is enabled, from a rising edge on one of several hardware trigger lines. A select field picks the line. The selected line is sampled once per system clock and compared against its previous sample. A 0-to-1 change is taken as a trigger. The block then waits a fixed number of synchronization cycles and issues a one-cycle start pulse together with a one-cycle prescaler reset. The prescaler reset gives the sample instant a fixed delay from the trigger.

While a conversion is under way the block masks every new request. Triggers that arrive during that time are dropped; they are not held for later. A line that is still high when the conversion ends does not start another one. One select value is reserved for the converter's own completion event. With that value selected, each completion immediately launches the next conversion, which gives free-running operation. The first conversion of such a run needs a software start.

Top module: `adc_trig_start`

## Requirements
- R1: After reset, `start` and `psc_rst` are low and the block is idle, accepting requests.
- R2: An automatic trigger is taken only while `auto_en` is 1, and only from the line `trig_src[src_sel]`. Rising edges on any other line, or any edge while `auto_en` is 0, produce no start.
- R3: If a 0-to-1 change on the selected line is first sampled at clock edge k, then `start` and `psc_rst` are both high for exactly one cycle, following edge k+SYNC_CYC-1. With the default SYNC_CYC=3, the downstream logic sees them at edge k+3.
- R4: A trigger edge is dropped, not queued, if it arrives while `busy` is 1 in the idle state or while a conversion is pending or running.
- R5: A selected line that is still high when a conversion ends starts nothing. Only a fresh 0-to-1 change starts the next conversion.
- R6: When `auto_en` is 1 and `src_sel` equals FREE_IDX (default 0), `trig_src[FREE_IDX]` is ignored. Instead, each `conv_cmpl` pulse during a conversion yields a `start` in the next cycle with `psc_rst` low. The first conversion needs `sw_start`.
- R7: `sw_start` sampled high while idle with `busy` low gives `start` for one cycle in the next cycle with `psc_rst` low, for any `auto_en`. It takes priority over a trigger edge in the same cycle and is ignored at any other time.
- R8: A change of `src_sel` never produces a trigger by itself, even if the newly selected line is already high.
- R9: If `auto_en` falls during the synchronization wait, the pending trigger is cancelled and no start is issued.
- R10: After a start, the block leaves the conversion state only on a `conv_cmpl` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Enables automatic triggering |
| src_sel | input | SEL_W (3) | Selects the trigger line (or free-running when equal to FREE_IDX) |
| trig_src | input | NSRC (8) | Hardware trigger lines |
| sw_start | input | 1 | Software conversion request |
| busy | input | 1 | Sequencer reports a conversion in progress |
| conv_cmpl | input | 1 | One-cycle pulse when a conversion finishes |
| start | output | 1 | One-cycle conversion start to the sequencer |
| psc_rst | output | 1 | One-cycle prescaler reset accompanying an automatic start |

## Verification
The checker watches four properties on every cycle:
- the block is quiet in the first cycle after reset;
- `start` is never longer than one cycle;
- a prescaler reset never appears unless automatic triggering was enabled;
- any start that is neither software- nor trigger-caused follows a completion pulse.

Some behaviour depends on history the checker does not see, so only the bench scenarios show it:
- the exact latency from an edge to `start`;
- the dropping of edges during a conversion;
- the need for a fresh edge after a level held across completion;
- the absence of a trigger on select changes;
- cancellation when `auto_en` falls.

The bench sweeps every selected line against every driven line, with automatic triggering both on and off.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYNC    = 3'd1,
        ST_TRIG_GO = 3'd2,
        ST_SW_GO   = 3'd3,
        ST_FREE_GO = 3'd4,
        ST_CONV    = 3'd5
    } trig_state_e;

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
    parameter int NSRC     = 8,
    parameter int SEL_W    = 3,
    parameter int FREE_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  trig_src,
    output logic             src_edge,
    output logic             free_run
);

    logic [NSRC-1:0]  hit;
    logic             sel_val;
    logic             hist_q;
    logic [SEL_W-1:0] prev_sel_q;
    logic             is_free;

    // one-hot pick of the selected line
    for (genvar i = 0; i < NSRC; i++) begin : g_pick
        assign hit[i] = trig_src[i] & (src_sel == SEL_W'(i));
    end

    assign sel_val = |hit;
    assign is_free = (src_sel == SEL_W'(FREE_IDX));

    // history follows whichever line is selected now; a select change
    // reloads it in the same cycle, so no edge is seen across the change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q     <= 1'b0;
            prev_sel_q <= '0;
        end else begin
            hist_q     <= sel_val;
            prev_sel_q <= src_sel;
        end
    end

    assign src_edge = auto_en & ~is_free & sel_val & ~hist_q & (src_sel == prev_sel_q);
    assign free_run = auto_en & is_free;

endmodule

// File: rtl/trig_start_fsm.sv
module trig_start_fsm
    import adc_trig_pkg::*;
#(
    parameter int SYNC_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic free_run,
    input  logic src_edge,
    input  logic sw_start,
    input  logic busy,
    input  logic conv_cmpl,
    output logic start,
    output logic psc_rst
);

    localparam int CNT_W = (SYNC_CYC > 2) ? $clog2(SYNC_CYC - 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SYNC_CYC - 2);

    trig_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sw_start && !busy) begin
                    state_d = ST_SW_GO;
                end else if (src_edge && !busy) begin
                    state_d = ST_SYNC;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_SYNC: begin
                if (!auto_en) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = ST_TRIG_GO;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_TRIG_GO: state_d = ST_CONV;
            ST_SW_GO:   state_d = ST_CONV;
            ST_FREE_GO: state_d = ST_CONV;
            ST_CONV: begin
                if (conv_cmpl) begin
                    state_d = free_run ? ST_FREE_GO : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start   = 1'b0;
        psc_rst = 1'b0;
        unique case (state_q)
            ST_TRIG_GO: begin
                start   = 1'b1;
                psc_rst = 1'b1;
            end
            ST_SW_GO:   start = 1'b1;
            ST_FREE_GO: start = 1'b1;
            default: begin
                start   = 1'b0;
                psc_rst = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adc_trig_start.sv
module adc_trig_start #(
    parameter int NSRC     = 8,
    parameter int SEL_W    = $clog2(NSRC),
    parameter int FREE_IDX = 0,
    parameter int SYNC_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  trig_src,
    input  logic             sw_start,
    input  logic             busy,
    input  logic             conv_cmpl,
    output logic             start,
    output logic             psc_rst
);

    logic src_edge;
    logic free_run;

    trig_edge_detect #(
        .NSRC     (NSRC),
        .SEL_W    (SEL_W),
        .FREE_IDX (FREE_IDX)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_en),
        .src_sel  (src_sel),
        .trig_src (trig_src),
        .src_edge (src_edge),
        .free_run (free_run)
    );

    trig_start_fsm #(
        .SYNC_CYC (SYNC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .free_run  (free_run),
        .src_edge  (src_edge),
        .sw_start  (sw_start),
        .busy      (busy),
        .conv_cmpl (conv_cmpl),
        .start     (start),
        .psc_rst   (psc_rst)
    );

endmodule

// File: rtl/trig_start_chk.sv
module trig_start_chk (
    input logic clk,
    input logic rst_n,
    input logic auto_en,
    input logic sw_start,
    input logic conv_cmpl,
    input logic start,
    input logic psc_rst
);

    // R1: quiet in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!start && !psc_rst));

    // R2: a prescaler reset needs automatic triggering enabled
    a_r2_psc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst |-> $past(auto_en));

    // R3: start lasts a single cycle
    a_r3_one_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R6: a start with no prescaler reset and no software request follows a completion
    a_r6_free_follows_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !psc_rst && !$past(sw_start)) |-> $past(conv_cmpl));

endmodule

bind adc_trig_start trig_start_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_en),
    .sw_start  (sw_start),
    .conv_cmpl (conv_cmpl),
    .start     (start),
    .psc_rst   (psc_rst)
);

// File: tb/sim_adc_trig_start.sv
module sim_adc_trig_start;

    localparam int NSRC     = 8;
    localparam int SEL_W    = 3;
    localparam int FREE_IDX = 0;
    localparam int SYNC_CYC = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             auto_en = 1'b0;
    logic [SEL_W-1:0] src_sel = '0;
    logic [NSRC-1:0]  trig_src = '0;
    logic             sw_start = 1'b0;
    logic             busy = 1'b0;
    logic             conv_cmpl = 1'b0;
    logic             start;
    logic             psc_rst;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    adc_trig_start #(
        .NSRC     (NSRC),
        .SEL_W    (SEL_W),
        .FREE_IDX (FREE_IDX),
        .SYNC_CYC (SYNC_CYC)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .src_sel   (src_sel),
        .trig_src  (trig_src),
        .sw_start  (sw_start),
        .busy      (busy),
        .conv_cmpl (conv_cmpl),
        .start     (start),
        .psc_rst   (psc_rst)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] exp);
        total++;
        if ({start, psc_rst} !== exp) begin
            bad++;
            $display("FAIL %s actual={start,psc_rst}=%b expected=%b", req, {start, psc_rst}, exp);
        end
    endtask

    task automatic end_conv();
        conv_cmpl = 1'b1;
        busy = 1'b0;
        step();
        conv_cmpl = 1'b0;
    endtask

    // one edge on line j with line sel selected
    task automatic auto_trial(input int sel, input int j, input logic en);
        logic [1:0] e;
        bit hit;
        hit = en && (j == sel);
        auto_en = en;
        src_sel = SEL_W'(sel);
        trig_src = '0;
        step();
        step();
        trig_src[j] = 1'b1;
        for (int c = 1; c <= SYNC_CYC + 1; c++) begin
            step();
            e = (hit && c == SYNC_CYC) ? 2'b11 : 2'b00;
            chk(hit ? "R3 edge latency" : "R2 unselected/disabled", e);
        end
        if (hit) end_conv();
        trig_src = '0;
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        chk("R1 during reset", 2'b00);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", 2'b00);

        // R2/R3 sweep: every selected line against every driven line
        for (int s = 1; s < NSRC; s++) begin
            for (int j = 0; j < NSRC; j++) begin
                auto_trial(s, j, 1'b1);
            end
            auto_trial(s, s, 1'b0);
        end

        // R7: software start, with auto enabled, plus R4/R10 masking
        auto_en = 1'b1;
        src_sel = 3'd4;
        step();
        step();
        sw_start = 1'b1;
        step();
        chk("R7 software start", 2'b10);
        sw_start = 1'b0;
        busy = 1'b1;
        step();
        chk("R10 in conversion", 2'b00);
        trig_src[4] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            chk("R4 edge during conversion", 2'b00);
        end
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
        step();
        chk("R7 software start while active ignored", 2'b00);
        trig_src[4] = 1'b0;
        step();
        trig_src[4] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            chk("R10 no exit without completion", 2'b00);
        end
        end_conv();
        chk("R5 completion with line high", 2'b00);
        for (int c = 0; c < 5; c++) begin
            step();
            chk("R5 level held high", 2'b00);
        end
        trig_src[4] = 1'b0;
        step();
        trig_src[4] = 1'b1;
        for (int c = 1; c <= SYNC_CYC; c++) begin
            step();
            chk("R5 fresh edge", (c == SYNC_CYC) ? 2'b11 : 2'b00);
        end
        step();
        end_conv();
        trig_src = '0;
        step();

        // R4: external busy while idle
        busy = 1'b1;
        trig_src[4] = 1'b1;
        for (int c = 0; c < 5; c++) begin
            step();
            chk("R4 edge while busy", 2'b00);
        end
        busy = 1'b0;
        for (int c = 0; c < 4; c++) begin
            step();
            chk("R4 dropped not queued", 2'b00);
        end
        trig_src = '0;
        step();

        // R8: select change onto a line that is already high
        src_sel = 3'd2;
        trig_src[5] = 1'b1;
        step();
        step();
        src_sel = 3'd5;
        for (int c = 0; c < 5; c++) begin
            step();
            chk("R8 select change", 2'b00);
        end
        trig_src[5] = 1'b0;
        step();
        trig_src[5] = 1'b1;
        for (int c = 1; c <= SYNC_CYC; c++) begin
            step();
            chk("R8 edge after change", (c == SYNC_CYC) ? 2'b11 : 2'b00);
        end
        step();
        end_conv();
        trig_src = '0;
        step();

        // R9: enable dropped during synchronization
        src_sel = 3'd3;
        step();
        trig_src[3] = 1'b1;
        step();
        auto_en = 1'b0;
        for (int c = 0; c < 4; c++) begin
            step();
            chk("R9 cancel on disable", 2'b00);
        end
        auto_en = 1'b1;
        trig_src = '0;
        step();

        // R7: software start beats a simultaneous edge
        src_sel = 3'd6;
        step();
        step();
        trig_src[6] = 1'b1;
        sw_start = 1'b1;
        step();
        chk("R7 software priority", 2'b10);
        sw_start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            step();
            chk("R7 edge swallowed", 2'b00);
        end
        end_conv();
        trig_src = '0;
        step();

        // R6: free-running
        src_sel = SEL_W'(FREE_IDX);
        step();
        trig_src[FREE_IDX] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            chk("R6 completion line not an edge source", 2'b00);
        end
        sw_start = 1'b1;
        step();
        chk("R6 first needs software start", 2'b10);
        sw_start = 1'b0;
        step();
        for (int n = 0; n < 4; n++) begin
            busy = 1'b1;
            step();
            chk("R6 running", 2'b00);
            end_conv();
            chk("R6 restart after completion", 2'b10);
            step();
        end
        src_sel = 3'd1;
        trig_src = '0;
        end_conv();
        for (int c = 0; c < 3; c++) begin
            chk("R6 stop when deselected", 2'b00);
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule